// File: doc/BRIEF.md
# Parallel ADC Frame Deframer

This block reads one conversion result out of an eight-channel simultaneous-sampling converter over a 16-bit parallel bus. It waits for the converter's busy line to drop, asserts chip select, and issues a train of read strobes of fixed low and high duration. Each bus word is latched on the last cycle of its strobe-low interval and placed into the right channel slot, so that the block delivers one sample per channel of 16 or 18 bits. Depending on the runtime options, it also extracts an 8-bit status byte per channel and a trailing 16-bit CRC word.

The sample width, the status option and the CRC option are sampled when each frame starts. A mode change during a frame therefore takes effect only on the next frame. When the last word is in, all channel outputs change in the same cycle and a one-cycle valid pulse marks them. Channels whose enable input is low are still read from the bus but are reported as zero. If a new busy fall arrives before the current frame has delivered its valid pulse, the block raises an overflow pulse and ignores that fall.

Top module: `par_adc_deframer`

## Requirements
- R1: After reset, cs_n_o and rd_n_o are 1; first_o, valid_o and overflow_o are 0; every sample, status and CRC output is 0.
- R2: A frame starts on the first clock edge at which busy_i is sampled 0 after it was sampled 1 on the previous edge (the detection edge). cs_n_o goes low after that edge and stays low for exactly N·RD_LOW + (N−1)·RD_HIGH cycles, ending with the last strobe-low interval. It is high when valid_o pulses.
- R3: The number of words per channel is 2 when wide_i or status_en_i is 1, and 1 otherwise. N equals 8 times the words per channel, plus 1 when crc_en_i is 1. Each word gets exactly one rd_n_o low interval of RD_LOW cycles, with RD_HIGH cycles high between intervals. The bus is sampled on the last low cycle.
- R4: In narrow mode (wide_i=0), the first word of each channel is the sample. Sample bits 17:16 are 0.
- R5: In wide mode (wide_i=1), the first word of a channel gives sample bits 17:2. Bus bits 15:14 of the second word give sample bits 1:0. The other bits of the second word do not affect the sample.
- R6: With status_en_i=1, the status byte comes from bus bits 15:8 of a channel's second word in narrow mode and from bus bits 7:0 in wide mode. With status_en_i=0, every status output is 0.
- R7: With crc_en_i=1, the final word of the frame appears on crc_o. With crc_en_i=0, crc_o is 0.
- R8: first_o is 1 only during the strobe-low interval of the frame's first word, for exactly RD_LOW cycles.
- R9: valid_o is high for exactly one cycle, in the cycle after the (N·RD_LOW + (N−1)·RD_HIGH + 1)-th clock edge after the detection edge. All channel outputs update in that same cycle.
- R10: A channel with chan_en_i bit low outputs a sample of 0 and a status of 0. chan_en_i is sampled when the frame completes.
- R11: wide_i, status_en_i and crc_en_i are captured at the detection edge. Changing them during a frame affects neither that frame's strobe count nor its decoding.
- R12: A busy fall detected while a frame is in progress (from its detection edge until its valid pulse) makes overflow_o high for one cycle, in the cycle after that edge. The frame in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | Converter busy line, synchronous to clk |
| wide_i | input | 1 | 1 selects 18-bit samples, 0 selects 16-bit |
| status_en_i | input | 1 | Per-channel status byte present |
| crc_en_i | input | 1 | Trailing CRC word present |
| chan_en_i | input | CH_N | Per-channel output enable |
| bus_i | input | BUS_W | Parallel data bus from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read strobe |
| first_o | output | 1 | High while the first word of the frame is read |
| sample_o | output | CH_N·(BUS_W+2) | Channel samples, channel 0 in the low bits |
| status_o | output | CH_N·8 | Channel status bytes, channel 0 in the low bits |
| crc_o | output | BUS_W | CRC word of the last frame |
| valid_o | output | 1 | One-cycle pulse when the outputs are new |
| overflow_o | output | 1 | One-cycle pulse on a busy fall during a frame |

## Verification
Each result has a fixed delay counted from the detection edge. The strobe train starts right after that edge. Each word is latched RD_LOW edges into its low interval. The last latch edge arrives after N·RD_LOW + (N−1)·RD_HIGH edges, and valid_o with all data outputs follows one edge later. The overflow pulse follows its own detection edge by one cycle. The bench drives every input on the falling clock edge and numbers the rising edges from the detection edge. At each falling edge it records chip select, strobe and marker activity. It then checks that valid_o appears at exactly the computed edge number and drops one cycle later, and only then compares the data outputs against values built from the generated bus words.

// File: rtl/par_adc_pkg.sv
// Shared types for the parallel ADC deframer.
// Assumes one read sequencer and one word unpacker per top instance.
package par_adc_pkg;

    // Sequencer phase: idle, strobe low, strobe high
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } rd_phase_t;

    // Frame format captured at frame start
    typedef struct packed {
        logic wide;   // 18-bit samples
        logic stat;   // status byte per channel
        logic crc;    // trailing CRC word
    } frame_mode_t;

endpackage

// File: rtl/adc_rd_sequencer.sv
// Read sequencer: detects the busy fall and runs chip select and the read
// strobe for one frame. It also tells the unpacker when to latch which word.
// Assumes busy_i is already synchronous to clk, and that RD_LOW and RD_HIGH are >= 1.
module adc_rd_sequencer
    import par_adc_pkg::*;
#(
    parameter int CH_N    = 8,
    parameter int RD_LOW  = 3,
    parameter int RD_HIGH = 3,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  frame_mode_t      mode_i,
    output logic             cs_n_o,
    output logic             rd_n_o,
    output logic             first_o,
    output logic             cap_o,
    output logic             start_o,
    output logic [IDX_W-1:0] widx_o,
    output frame_mode_t      mode_o,
    output logic             commit_o,
    output logic             ovf_o
);
    localparam int CNT_MAX = (RD_LOW > RD_HIGH) ? RD_LOW : RD_HIGH;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(RD_LOW - 1);
    localparam logic [CNT_W-1:0] HIGH_END = CNT_W'(RD_HIGH - 1);
    localparam logic [IDX_W-1:0] LAST_1W  = IDX_W'(CH_N - 1);
    localparam logic [IDX_W-1:0] LAST_2W  = IDX_W'(2 * CH_N - 1);

    rd_phase_t        phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] widx_q;
    frame_mode_t      mode_q;
    logic             busy_q;
    logic             commit_q;
    logic             ovf_q;
    logic             busy_fall;
    logic             in_frame;
    logic             last_word;
    logic [IDX_W-1:0] last_idx;

    // Frame-level combinational decode
    always_comb begin
        busy_fall = busy_q & ~busy_i;
        in_frame  = (phase_q != PH_IDLE) | commit_q;
        last_idx  = ((mode_q.wide | mode_q.stat) ? LAST_2W : LAST_1W)
                    + IDX_W'(mode_q.crc);
        last_word = (widx_q == last_idx);
        cap_o     = (phase_q == PH_LOW) && (cnt_q == LOW_END);
        start_o   = (phase_q == PH_IDLE) && busy_fall && !commit_q;
    end

    // Phase, strobe counter, word index and mode capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            widx_q   <= '0;
            mode_q   <= '0;
            busy_q   <= 1'b0;
            commit_q <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            busy_q   <= busy_i;
            commit_q <= 1'b0;
            ovf_q    <= busy_fall & in_frame;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_o) begin
                        phase_q <= PH_LOW;
                        cnt_q   <= '0;
                        widx_q  <= '0;
                        mode_q  <= mode_i;
                    end
                end
                PH_LOW: begin
                    if (cnt_q == LOW_END) begin
                        cnt_q <= '0;
                        if (last_word) begin
                            phase_q  <= PH_IDLE;
                            commit_q <= 1'b1;
                        end else begin
                            phase_q <= PH_HIGH;
                            widx_q  <= widx_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt_q == HIGH_END) begin
                        cnt_q   <= '0;
                        phase_q <= PH_LOW;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign cs_n_o   = (phase_q == PH_IDLE);
    assign rd_n_o   = (phase_q != PH_LOW);
    assign first_o  = (phase_q == PH_LOW) && (widx_q == '0);
    assign widx_o   = widx_q;
    assign mode_o   = mode_q;
    assign commit_o = commit_q;
    assign ovf_o    = ovf_q;

endmodule

// File: rtl/adc_word_unpack.sv
// Word unpacker: sorts each latched bus word into the channel sample, status
// or CRC holding registers, according to the word index and the frame mode.
// Assumes the holding registers are read only after the frame has ended.
module adc_word_unpack
    import par_adc_pkg::*;
#(
    parameter int CH_N  = 8,
    parameter int BUS_W = 16,
    parameter int IDX_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        cap_i,
    input  logic [IDX_W-1:0]            widx_i,
    input  frame_mode_t                 mode_i,
    input  logic [BUS_W-1:0]            bus_i,
    output logic [CH_N*(BUS_W+2)-1:0]   samp_o,
    output logic [CH_N*8-1:0]           stat_o,
    output logic [BUS_W-1:0]            crc_o
);
    localparam int SW = BUS_W + 2;
    localparam logic [IDX_W-1:0] CRC_1W = IDX_W'(CH_N);
    localparam logic [IDX_W-1:0] CRC_2W = IDX_W'(2 * CH_N);

    logic             two_words;
    logic [IDX_W-1:0] crc_idx;
    logic [BUS_W-1:0] crc_q;

    // Mode-dependent word layout
    always_comb begin
        two_words = mode_i.wide | mode_i.stat;
        crc_idx   = two_words ? CRC_2W : CRC_1W;
    end

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_chan
        localparam logic [IDX_W-1:0] ONE_IDX = IDX_W'(ch);
        localparam logic [IDX_W-1:0] HI_IDX  = IDX_W'(2 * ch);
        localparam logic [IDX_W-1:0] LO_IDX  = IDX_W'(2 * ch + 1);
        logic [SW-1:0] s_q;
        logic [7:0]    st_q;

        // Collect this channel's sample and status from its words
        always_ff @(posedge clk) begin
            if (!rst_n || start_i) begin
                s_q  <= '0;
                st_q <= '0;
            end else if (cap_i) begin
                if (!two_words && widx_i == ONE_IDX) begin
                    s_q <= {2'b00, bus_i};
                end
                if (two_words && widx_i == HI_IDX) begin
                    s_q <= mode_i.wide ? {bus_i, 2'b00} : {2'b00, bus_i};
                end
                if (two_words && widx_i == LO_IDX) begin
                    if (mode_i.wide) begin
                        s_q[1:0] <= bus_i[BUS_W-1 -: 2];
                    end
                    if (mode_i.stat) begin
                        st_q <= mode_i.wide ? bus_i[7:0] : bus_i[BUS_W-1 -: 8];
                    end
                end
            end
        end

        assign samp_o[ch*SW +: SW] = s_q;
        assign stat_o[ch*8 +: 8]   = st_q;
    end

    // Capture the trailing CRC word
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            crc_q <= '0;
        end else if (cap_i && mode_i.crc && widx_i == crc_idx) begin
            crc_q <= bus_i;
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/par_adc_deframer.sv
// Top level: sequencer, unpacker and an output stage that publishes all
// channels together with the valid pulse. Disabled channels are zeroed there.
// Assumes all inputs are synchronous to clk.
module par_adc_deframer
    import par_adc_pkg::*;
#(
    parameter int CH_N    = 8,
    parameter int BUS_W   = 16,
    parameter int RD_LOW  = 3,
    parameter int RD_HIGH = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      busy_i,
    input  logic                      wide_i,
    input  logic                      status_en_i,
    input  logic                      crc_en_i,
    input  logic [CH_N-1:0]           chan_en_i,
    input  logic [BUS_W-1:0]          bus_i,
    output logic                      cs_n_o,
    output logic                      rd_n_o,
    output logic                      first_o,
    output logic [CH_N*(BUS_W+2)-1:0] sample_o,
    output logic [CH_N*8-1:0]         status_o,
    output logic [BUS_W-1:0]          crc_o,
    output logic                      valid_o,
    output logic                      overflow_o
);
    localparam int SW    = BUS_W + 2;
    localparam int IDX_W = $clog2(2 * CH_N + 2);

    frame_mode_t             mode_in;
    frame_mode_t             mode_frm;
    logic                    cap;
    logic                    start;
    logic                    commit;
    logic [IDX_W-1:0]        widx;
    logic [CH_N*SW-1:0]      sh_samp;
    logic [CH_N*8-1:0]       sh_stat;
    logic [BUS_W-1:0]        sh_crc;
    logic                    valid_q;

    assign mode_in = '{wide: wide_i, stat: status_en_i, crc: crc_en_i};

    adc_rd_sequencer #(
        .CH_N(CH_N), .RD_LOW(RD_LOW), .RD_HIGH(RD_HIGH), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .mode_i(mode_in),
        .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .first_o(first_o), .cap_o(cap),
        .start_o(start), .widx_o(widx), .mode_o(mode_frm),
        .commit_o(commit), .ovf_o(overflow_o)
    );

    adc_word_unpack #(
        .CH_N(CH_N), .BUS_W(BUS_W), .IDX_W(IDX_W)
    ) u_unpack (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cap_i(cap),
        .widx_i(widx), .mode_i(mode_frm), .bus_i(bus_i),
        .samp_o(sh_samp), .stat_o(sh_stat), .crc_o(sh_crc)
    );

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_out
        // Publish one channel at frame end, zeroed when disabled
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sample_o[ch*SW +: SW] <= '0;
                status_o[ch*8 +: 8]   <= '0;
            end else if (commit) begin
                sample_o[ch*SW +: SW] <= chan_en_i[ch] ? sh_samp[ch*SW +: SW] : '0;
                status_o[ch*8 +: 8]   <= chan_en_i[ch] ? sh_stat[ch*8 +: 8] : '0;
            end
        end
    end

    // Publish the CRC word and the valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_o   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= commit;
            if (commit) begin
                crc_o <= sh_crc;
            end
        end
    end

    assign valid_o = valid_q;

endmodule

// File: rtl/par_adc_deframer_chk.sv
// Protocol checker for the deframer's port behaviour. It is bound to every
// instance of the top module.
module par_adc_deframer_chk #(
    parameter int RD_LOW = 3
) (
    input logic clk,
    input logic rst_n,
    input logic busy_i,
    input logic cs_n_o,
    input logic rd_n_o,
    input logic first_o,
    input logic valid_o,
    input logic overflow_o
);
    localparam int RUN_W = $clog2(RD_LOW + 1);
    logic [RUN_W-1:0] low_run;

    // Count the strobe-low cycles already elapsed in the current interval
    always_ff @(posedge clk) begin
        if (!rst_n || rd_n_o) low_run <= '0;
        else                  low_run <= low_run + 1'b1;
    end

    p_rd_inside_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !cs_n_o);
    p_cs_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(!busy_i));
    p_low_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> (low_run < RUN_W'(RD_LOW)));
    p_low_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n_o) |-> ($past(low_run) == RUN_W'(RD_LOW - 1)));
    p_first_in_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        first_o |-> !rd_n_o);
    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    p_valid_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> cs_n_o);
    p_ovf_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> ($past(!busy_i) && $past(busy_i, 2)));
    p_ovf_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> !overflow_o);

endmodule

bind par_adc_deframer par_adc_deframer_chk #(.RD_LOW(RD_LOW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .cs_n_o(cs_n_o),
    .rd_n_o(rd_n_o), .first_o(first_o), .valid_o(valid_o),
    .overflow_o(overflow_o)
);

// File: tb/par_adc_deframer_test.sv
`timescale 1ns/1ps
module par_adc_deframer_test;
    localparam int CH = 8;
    localparam int BW = 16;
    localparam int SW = BW + 2;
    localparam int L  = 3;
    localparam int H  = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n, busy, wide, stat_en, crc_en;
    logic [CH-1:0]     chan_en;
    logic [BW-1:0]     bus;
    logic              cs_n, rd_n, first, valid, ovf;
    logic [CH*SW-1:0]  sample;
    logic [CH*8-1:0]   status;
    logic [BW-1:0]     crc;

    par_adc_deframer #(.CH_N(CH), .BUS_W(BW), .RD_LOW(L), .RD_HIGH(H)) uut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .wide_i(wide),
        .status_en_i(stat_en), .crc_en_i(crc_en), .chan_en_i(chan_en),
        .bus_i(bus), .cs_n_o(cs_n), .rd_n_o(rd_n), .first_o(first),
        .sample_o(sample), .status_o(status), .crc_o(crc),
        .valid_o(valid), .overflow_o(ovf)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    logic [BW-1:0] words [0:2*CH+1];
    int   widx = 0;
    logic rd_prev = 1'b1;

    // Converter model: advance one word per completed strobe
    always @(negedge clk) begin
        if (cs_n) widx <= 0;
        else if (!rd_prev && rd_n) widx <= widx + 1;
        rd_prev <= rd_n;
    end
    assign bus = rd_n ? 16'hA5C3 : words[widx];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    function automatic int frame_words(input bit w, input bit s, input bit c);
        return CH * ((w || s) ? 2 : 1) + (c ? 1 : 0);
    endfunction

    task automatic run_frame(input bit w, input bit s, input bit c,
                             input logic [CH-1:0] en, input bit flip, input bit inj);
        logic [SW-1:0] es [CH];
        logic [7:0]    est [CH];
        logic [BW-1:0] ecrc;
        int per, nw, span, j, cs_cnt, reads, run, bad_run, fcnt, fbad, ocnt, vj;
        string stag;
        per  = (w || s) ? 2 : 1;
        nw   = frame_words(w, s, c);
        span = nw * L + (nw - 1) * H;
        for (int ch = 0; ch < CH; ch++) begin
            es[ch]  = w ? SW'($urandom()) : {2'b00, 16'($urandom())};
            est[ch] = s ? 8'($urandom()) : 8'h00;
            if (!w) begin
                words[ch*per] = es[ch][15:0];
                if (s) words[ch*2+1] = {est[ch], 8'h00};
            end else begin
                words[ch*2]   = es[ch][17:2];
                words[ch*2+1] = s ? {es[ch][1:0], 6'b0, est[ch]}
                                  : {es[ch][1:0], 14'($urandom())};
            end
        end
        ecrc = c ? 16'($urandom()) : 16'h0000;
        if (c) words[CH*per] = ecrc;
        wide = w; stat_en = s; crc_en = c; chan_en = en;
        busy = 1'b1;
        repeat (2) @(negedge clk);
        busy = 1'b0;
        @(posedge clk);
        j = 0; cs_cnt = 0; reads = 0; run = 0; bad_run = 0;
        fcnt = 0; fbad = 0; ocnt = 0; vj = -1;
        while (j < 5000) begin
            @(negedge clk);
            if (ovf) ocnt++;
            if (valid) begin vj = j; break; end
            if (!cs_n) cs_cnt++;
            if (!rd_n) begin
                if (run == 0) reads++;
                run++;
            end else if (run != 0) begin
                if (run != L) bad_run++;
                run = 0;
            end
            if (first) begin
                fcnt++;
                if (reads != 1 || rd_n) fbad++;
            end
            if (flip && j == 4) begin wide = ~w; stat_en = ~s; crc_en = ~c; end
            if (inj && j == 10) busy = 1'b1;
            if (inj && j == 12) busy = 1'b0;
            @(posedge clk);
            j++;
        end
        stag = flip ? "R11" : "";
        chk("R9 valid edge", vj, span + 1);
        chk("R2 cs released at valid", cs_n, 1'b1);
        chk("R2 cs low cycles", cs_cnt, span);
        chk(flip ? "R11 word count" : "R3 word count", reads, nw);
        chk("R3 strobe low width", bad_run, 0);
        chk("R8 first marker cycles", fcnt, L);
        chk("R8 first marker placement", fbad, 0);
        chk("R12 overflow pulses", ocnt, inj ? 1 : 0);
        for (int ch = 0; ch < CH; ch++) begin
            string t;
            t = (stag != "") ? stag : (!en[ch] ? "R10" : (w ? "R5" : "R4"));
            chk($sformatf("%s sample ch%0d", t, ch), 32'(sample[ch*SW +: SW]),
                en[ch] ? 32'(es[ch]) : 32'h0);
            t = (stag != "") ? stag : (!en[ch] ? "R10" : "R6");
            chk($sformatf("%s status ch%0d", t, ch), 32'(status[ch*8 +: 8]),
                en[ch] ? 32'(est[ch]) : 32'h0);
        end
        chk((stag != "") ? "R11 crc" : "R7 crc", 32'(crc), 32'(ecrc));
        @(posedge clk);
        @(negedge clk);
        chk("R9 valid one cycle", valid, 1'b0);
        wide = 1'b0; stat_en = 1'b0; crc_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; busy = 1'b0; wide = 1'b0; stat_en = 1'b0;
        crc_en = 1'b0; chan_en = '1;
        for (int i = 0; i < 2*CH+2; i++) words[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs_n", cs_n, 1'b1);
        chk("R1 rd_n", rd_n, 1'b1);
        chk("R1 first", first, 1'b0);
        chk("R1 valid", valid, 1'b0);
        chk("R1 overflow", ovf, 1'b0);
        chk("R1 samples", 32'(|sample), 32'h0);
        chk("R1 status", 32'(|status), 32'h0);
        chk("R1 crc", 32'(crc), 32'h0);
        // Directed corner cases
        run_frame(1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0);
        run_frame(1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0);
        run_frame(1'b0, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0);
        run_frame(1'b1, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0);
        run_frame(1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0);
        run_frame(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        run_frame(1'b0, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b0);
        run_frame(1'b1, 1'b0, 1'b0, 8'hC3, 1'b1, 1'b0);
        run_frame(1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b1);
        run_frame(1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1);
        // Constrained random frames
        for (int k = 0; k < 30; k++) begin
            run_frame(1'($urandom()), 1'($urandom()), 1'($urandom()),
                      8'($urandom()), 1'($urandom_range(0, 5) == 0),
                      1'($urandom_range(0, 5) == 0));
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule